// File: doc/BRIEF.md
# Display Controller Host Register Port

This block is the host-facing register port of an eight-position character display controller. A host processor drives asynchronous-style strobes (active-low chip enable, write and read), a flash-select line, a five-bit address and a bidirectional eight-bit data bus. The block samples these on its own system clock. It turns each access into an update or readback of one storage section: per-position character codes, a per-position flash attribute, an index register that points at one user-defined glyph, the glyph row storage, and a control register.

The block also runs two timed fill sequences. Both are paced by a refresh tick input. A clear starts when the host writes the top control bit. It fills every character position with the space code and sets every flash bit. The initialisation sequence follows reset release. It fills the character positions with spaces and zeroes the flash bits and the control register. The glyph storage and its index register are untouched by either sequence. While a sequence or an external self-test runs, a busy output is high and host writes are discarded.

Top module: `disp_host_port`

## Requirements
- R1: With flash-select low, the access reaches the flash attribute bit of position addr[2:0], whatever addr[4:3] holds. A write stores data[0]. A read returns the bit on data[0] with data[7:1]=0.
- R2: With flash-select high, addr[4:3] picks the section: 00 glyph index register, 01 glyph rows, 10 control register, 11 character positions. An access to one section leaves all other sections unchanged.
- R3: A character write stores all eight data bits at position addr[2:0]. A read of that position returns them unchanged.
- R4: A glyph index write keeps only data[3:0] and ignores addr[2:0]. A read returns the index in data[3:0] with data[7:4]=0.
- R5: A glyph row write stores data[4:0] into row addr[2:0] of the glyph chosen by the index register. data[7:5] are dropped and read back as 0. Row address 7 is not stored and reads as 0. Rows of other glyphs are unaffected.
- R6: Each chip-enable assertion with write low commits exactly one write. Write low with chip enable high, or chip enable low with no strobe, changes nothing.
- R7: A control write stores every bit except bit 5. A control read returns the stored bits with bit 5 replaced by the self-test result input.
- R8: A control write with bit 7 set raises busy. After three refresh ticks, all eight positions hold 20h, all flash bits are 1 and control bit 7 reads 0. Control bits 6, 4..0, the glyph index and the glyph rows keep their values.
- R9: After reset release, busy stays high for three refresh ticks. Then all positions hold 20h and the flash bits and control register read 0 (bit 5 aside). The glyph index and glyph rows keep the values they had before reset.
- R10: Host writes are ignored while busy is high. Busy is high during a clear, during the initialisation sequence, and while the self-test-running input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_tick | input | 1 | One-cycle pulse per refresh clock; paces the fill sequences |
| selftest_busy | input | 1 | High while an external self-test runs |
| selftest_pass | input | 1 | Self-test result, read back as control bit 5 |
| cs_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| fl_n | input | 1 | Active-low flash attribute select |
| addr | input | 5 | Section select [4:3] and index [2:0] |
| data | inout | 8 | Host data bus, driven by the block only during a read |
| busy | output | 1 | Fill sequence or self-test in progress |

## Verification
The in-line properties watch, on every cycle, that a strobe commits at most one write and that the sequence counter stays inside its tick window. They also check that the fill values appear in the cycle after a clear or initialisation completes, and that the glyph index holds still while busy is high. The bench scenarios show the rest through the bus: section decode and the flash-line override, and field masking with read-back zeros. They also cover the dropped row 7, glyph contents kept across clear and reset, and writes discarded during a clear or self-test.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [2:0] {
    SEC_FLASH, SEC_UIDX, SEC_UROW, SEC_CTRL, SEC_CHAR
  } sec_e;

  localparam logic [7:0] SPACE_CODE = 8'h20;
  localparam int         RO_BIT     = 5;
  localparam int         CLR_BIT    = 7;

  function automatic sec_e sec_decode(input logic fl_n, input logic [1:0] hi);
    if (!fl_n) return SEC_FLASH;
    case (hi)
      2'b00:   return SEC_UIDX;
      2'b01:   return SEC_UROW;
      2'b10:   return SEC_CTRL;
      default: return SEC_CHAR;
    endcase
  endfunction
endpackage

// File: rtl/disp_strobe_sync.sv
module disp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic cs_n,
  input  logic wr_n,
  output logic wr_stb
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], ~cs_n & ~wr_n};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign wr_stb = sync_q[STAGES-1] & ~prev_q;

  // R6
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/disp_fill_seq.sv
module disp_fill_seq #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick,
  input  logic clr_req,
  output logic active,
  output logic is_init,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);

  logic          act_q, act_d;
  logic          init_q, init_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done    = act_q & tick & (cnt_q == CW'(TICKS - 1));
  assign active  = act_q;
  assign is_init = init_q;

  always_comb begin
    act_d  = act_q;
    init_d = init_q;
    cnt_d  = cnt_q;
    if (act_q) begin
      if (done) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else if (tick) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (clr_req) begin
      act_d  = 1'b1;
      init_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b1;
      init_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      init_q <= init_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8
  seq_len_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    act_q |-> (cnt_q < CW'(TICKS)));
endmodule

// File: rtl/disp_store.sv
module disp_store
  import disp_pkg::*;
#(
  parameter int NPOS = 8,
  parameter int NUDC = 16,
  parameter int NROW = 7,
  parameter int NCOL = 5,
  parameter int IW   = $clog2(NPOS)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          we,
  input  sec_e          sec,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  input  logic          seq_done,
  input  logic          seq_init,
  input  logic          busy,
  input  logic          st_pass,
  output logic [7:0]    rdata
);
  localparam int UAW  = $clog2(NUDC);
  localparam int MEMD = NUDC * NROW;
  localparam int MAW  = $clog2(MEMD);

  logic [7:0]      chr_q [NPOS];
  logic [7:0]      chr_d [NPOS];
  logic [NPOS-1:0] flash_q, flash_d;
  logic [7:0]      ctrl_q, ctrl_d;
  logic [UAW-1:0]  ua_q, ua_d;
  logic [NCOL-1:0] mem [MEMD];
  logic            row_ok;
  logic [MAW-1:0]  mem_a;

  assign row_ok = (int'(idx) < NROW);
  assign mem_a  = MAW'(int'(ua_q) * NROW + int'(idx));

  always_comb begin
    chr_d   = chr_q;
    flash_d = flash_q;
    ctrl_d  = ctrl_q;
    ua_d    = ua_q;
    if (seq_done) begin
      for (int i = 0; i < NPOS; i++) chr_d[i] = SPACE_CODE;
      flash_d = seq_init ? '0 : '1;
      ctrl_d  = seq_init ? 8'h00 : (ctrl_q & ~(8'h1 << CLR_BIT));
    end else if (we) begin
      case (sec)
        SEC_FLASH: flash_d[idx] = wdata[0];
        SEC_UIDX:  ua_d         = wdata[UAW-1:0];
        SEC_CTRL:  ctrl_d       = wdata & ~(8'h1 << RO_BIT);
        SEC_CHAR:  chr_d[idx]   = wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPOS; i++) chr_q[i] <= SPACE_CODE;
      flash_q <= '0;
      ctrl_q  <= 8'h00;
    end else begin
      chr_q   <= chr_d;
      flash_q <= flash_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_ff @(posedge clk) begin
    ua_q <= ua_d;
    if (we && !seq_done && sec == SEC_UROW && row_ok)
      mem[mem_a] <= wdata[NCOL-1:0];
  end

  always_comb begin
    rdata = 8'h00;
    case (sec)
      SEC_FLASH: rdata[0]       = flash_q[idx];
      SEC_UIDX:  rdata[UAW-1:0] = ua_q;
      SEC_UROW:  if (row_ok) rdata[NCOL-1:0] = mem[mem_a];
      SEC_CTRL: begin
        rdata         = ctrl_q;
        rdata[RO_BIT] = st_pass;
      end
      default:   rdata = chr_q[idx];
    endcase
  end

  // R8
  clr_fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (seq_done && !seq_init) |=> (chr_q[0] == SPACE_CODE &&
      chr_q[NPOS-1] == SPACE_CODE && (&flash_q) && !ctrl_q[CLR_BIT]));
  // R9
  init_fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (seq_done && seq_init) |=> (flash_q == '0 && ctrl_q == 8'h00));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(ua_q));
endmodule

// File: rtl/disp_host_port.sv
module disp_host_port
  import disp_pkg::*;
#(
  parameter int NPOS      = 8,
  parameter int NUDC      = 16,
  parameter int NROW      = 7,
  parameter int NCOL      = 5,
  parameter int SEQ_TICKS = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refresh_tick,
  input  logic       selftest_busy,
  input  logic       selftest_pass,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       fl_n,
  input  logic [4:0] addr,
  inout  wire  [7:0] data,
  output logic       busy
);
  localparam int IW = $clog2(NPOS);

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       wr_stb, wr_go, clr_req;
  logic       seq_act, seq_init, seq_done;
  sec_e       sec;
  logic [7:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign sec     = sec_decode(fl_n, addr[4:3]);
  assign busy    = seq_act | selftest_busy;
  assign wr_go   = wr_stb & ~busy;
  assign clr_req = wr_go & (sec == SEC_CTRL) & data[CLR_BIT];
  assign data    = (!cs_n && !rd_n) ? rdata : 8'hzz;

  disp_strobe_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .cs_n(cs_n), .wr_n(wr_n), .wr_stb(wr_stb)
  );

  disp_fill_seq #(.TICKS(SEQ_TICKS)) u_seq (
    .clk(clk), .rst_ni(rst_ni), .tick(refresh_tick), .clr_req(clr_req),
    .active(seq_act), .is_init(seq_init), .done(seq_done)
  );

  disp_store #(.NPOS(NPOS), .NUDC(NUDC), .NROW(NROW), .NCOL(NCOL)) u_store (
    .clk(clk), .rst_ni(rst_ni), .we(wr_go), .sec(sec), .idx(addr[IW-1:0]),
    .wdata(data), .seq_done(seq_done), .seq_init(seq_init), .busy(busy),
    .st_pass(selftest_pass), .rdata(rdata)
  );
endmodule

// File: tb/disp_host_port_test.sv
module disp_host_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refresh_tick = 1'b0;
  logic       selftest_busy = 1'b0;
  logic       selftest_pass = 1'b1;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, fl_n = 1'b1;
  logic [4:0] addr = '0;
  logic       drv_en = 1'b0;
  logic [7:0] drv_val = '0;
  wire  [7:0] data;
  logic       busy;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] m_chr [8];
  logic [7:0] m_fl;
  logic [7:0] v;

  assign data = drv_en ? drv_val : 8'hzz;

  disp_host_port uut (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick),
    .selftest_busy(selftest_busy), .selftest_pass(selftest_pass),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .fl_n(fl_n), .addr(addr),
    .data(data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (TICK_DIV - 1) @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);
    refresh_tick = 1'b0;
  end

  function automatic logic [7:0] exp_ctrl(input logic [7:0] w, input logic st);
    return (w & 8'hDF) | {2'b00, st, 5'b00000};
  endfunction

  function automatic logic [7:0] exp_row(input logic [7:0] w);
    return {3'b000, w[4:0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    fl_n = fl; addr = a; drv_val = d; drv_en = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    drv_en = 1'b0; fl_n = 1'b1;
  endtask

  task automatic rd(input logic fl, input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    fl_n = fl; addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1 d = data;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; fl_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic check_fill(input string req, input logic [7:0] fl_exp);
    for (int p = 0; p < 8; p++) begin
      rd(1'b1, {2'b11, 3'(p)}, v); check(req, v, 8'h20);
      rd(1'b0, {2'b00, 3'(p)}, v); check(req, v, {7'b0, fl_exp[p]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rows [7];
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 busy after reset", {7'b0, busy}, 8'h01);
    wait_idle();
    // R9 reset state
    check_fill("R9 init fill", 8'h00);
    rd(1'b1, 5'b10000, v); check("R9 ctrl init", v, exp_ctrl(8'h00, 1'b1));

    // R3 character positions
    wr(1'b1, 5'b11000, 8'hC1); wr(1'b1, 5'b11111, 8'h7E);
    rd(1'b1, 5'b11000, v); check("R3 pos0", v, 8'hC1);
    rd(1'b1, 5'b11111, v); check("R3 pos7", v, 8'h7E);
    // R2 char write did not reach control
    rd(1'b1, 5'b10000, v); check("R2 ctrl untouched", v, exp_ctrl(8'h00, 1'b1));

    // R1 flash line overrides addr[4:3]
    wr(1'b0, 5'b10011, 8'hFF);
    rd(1'b0, 5'b01011, v); check("R1 flash set", v, 8'h01);
    rd(1'b1, 5'b10000, v); check("R1 ctrl untouched", v, exp_ctrl(8'h00, 1'b1));
    rd(1'b1, 5'b11011, v); check("R1 char untouched", v, 8'h20);
    wr(1'b0, 5'b11011, 8'hFE);
    rd(1'b0, 5'b00011, v); check("R1 flash clear", v, 8'h00);

    // R4 glyph index
    wr(1'b1, 5'b00101, 8'hF9);
    rd(1'b1, 5'b00010, v); check("R4 index", v, 8'h09);

    // R5 glyph rows
    for (int r = 0; r < 7; r++) begin
      rows[r] = 8'($urandom);
      wr(1'b1, {2'b01, 3'(r)}, rows[r]);
    end
    wr(1'b1, 5'b01111, 8'h1F);
    rd(1'b1, 5'b01111, v); check("R5 row7", v, 8'h00);
    wr(1'b1, 5'b00000, 8'h02);
    wr(1'b1, 5'b01000, 8'h15);
    wr(1'b1, 5'b00000, 8'h09);
    for (int r = 0; r < 7; r++) begin
      rd(1'b1, {2'b01, 3'(r)}, v); check("R5 row data", v, exp_row(rows[r]));
    end
    wr(1'b1, 5'b00000, 8'h02);
    rd(1'b1, 5'b01000, v); check("R5 other glyph", v, 8'h15);
    wr(1'b1, 5'b00000, 8'h09);

    // R6 strobes without both lines low
    @(negedge clk); addr = 5'b11000; drv_val = 8'h55; drv_en = 1'b1;
    wr_n = 1'b0; repeat (6) @(negedge clk); wr_n = 1'b1;
    cs_n = 1'b0; repeat (6) @(negedge clk); cs_n = 1'b1;
    @(negedge clk); drv_en = 1'b0;
    rd(1'b1, 5'b11000, v); check("R6 no write", v, 8'hC1);

    // R7 control register
    wr(1'b1, 5'b10000, 8'h5F);
    rd(1'b1, 5'b10000, v); check("R7 ctrl st1", v, exp_ctrl(8'h5F, 1'b1));
    selftest_pass = 1'b0;
    wr(1'b1, 5'b10000, 8'h3A);
    rd(1'b1, 5'b10000, v); check("R7 ctrl st0", v, exp_ctrl(8'h3A, 1'b0));
    selftest_pass = 1'b1;

    // random character and flash traffic
    for (int p = 0; p < 8; p++) begin m_chr[p] = 8'h20; m_fl[p] = 1'b0; end
    rd(1'b1, 5'b11000, v); m_chr[0] = v;
    rd(1'b1, 5'b11111, v); m_chr[7] = v;
    for (int i = 0; i < 30; i++) begin
      int p = int'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr(1'b1, {2'b11, 3'(p)}, d); m_chr[p] = d;
      end else begin
        wr(1'b0, {2'($urandom), 3'(p)}, d); m_fl[p] = d[0];
      end
    end
    for (int p = 0; p < 8; p++) begin
      rd(1'b1, {2'b11, 3'(p)}, v); check("R3 random char", v, m_chr[p]);
      rd(1'b0, {2'b00, 3'(p)}, v); check("R1 random flash", v, {7'b0, m_fl[p]});
    end

    // R8 clear, with a write during busy (R10)
    wr(1'b1, 5'b10000, 8'hD3);
    check("R8 busy raised", {7'b0, busy}, 8'h01);
    rd(1'b1, 5'b10000, v); check("R8 bit7 while busy", v, exp_ctrl(8'hD3, 1'b1));
    wr(1'b1, 5'b11000, 8'h41);
    wait_idle();
    check_fill("R8 clear fill", 8'hFF);
    rd(1'b1, 5'b10000, v); check("R8 ctrl after", v, exp_ctrl(8'h53, 1'b1));
    rd(1'b1, 5'b00000, v); check("R8 index kept", v, 8'h09);
    rd(1'b1, 5'b01011, v); check("R8 row kept", v, exp_row(rows[3]));

    // R10 self-test busy
    selftest_busy = 1'b1;
    @(negedge clk);
    check("R10 busy out", {7'b0, busy}, 8'h01);
    wr(1'b1, 5'b00000, 8'h04);
    wr(1'b1, 5'b11010, 8'h99);
    selftest_busy = 1'b0;
    rd(1'b1, 5'b00000, v); check("R10 index ignored", v, 8'h09);
    rd(1'b1, 5'b11010, v); check("R10 char ignored", v, 8'h20);

    // R9 reset mid-run keeps glyph state
    wr(1'b1, 5'b10000, 8'h15);
    wr(1'b0, 5'b00001, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 busy after re-reset", {7'b0, busy}, 8'h01);
    wait_idle();
    check_fill("R9 re-init fill", 8'h00);
    rd(1'b1, 5'b10000, v); check("R9 ctrl zero", v, exp_ctrl(8'h00, 1'b1));
    rd(1'b1, 5'b00000, v); check("R9 index kept", v, 8'h09);
    rd(1'b1, 5'b01110, v); check("R9 row kept", v, exp_row(rows[6]));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule